// File: doc/BRIEF.md
# PTP Egress Correction Field Updater

This block sits in the transmit path of a packet stream and rewrites outgoing precision-time-protocol frames as they pass. For every packet the sender presents control bits, three byte offsets and a pair of timestamps together with the first beat. From the timestamps the block derives a residence time. It adds that time into the 64-bit correction field found at the chosen offset. It can also clear a UDP/IPv4 checksum, or adjust a UDP/IPv6 checksum-correction word so that the checksum stays valid after the rewrite.

The stream is byte-wide, with start and end of packet markers and valid/ready flow control on both sides. Beats pass through a delay line of `DEPTH` entries. A beat leaves only once the line is full, or once the packet's last beat has entered. Every value written into a byte is therefore known before that byte reaches the output. Only one packet is inside the block at a time. Header parsing and timestamp generation are done elsewhere.

Top module: `ptp_cf_updater`

## Requirements
- R1: Control bits, offsets and both timestamps are taken only on the accepted beat that carries `in_sop`; changing them on any later beat of the packet changes nothing at the output.
- R2: With `ctl_fmt64`=1 the residence time is `ts_egress[63:0] - ts_ingress[63:0]` modulo 2^64, in units of 2^-16 ns.
- R3: With `ctl_fmt64`=0 each timestamp is split into seconds [95:48], nanoseconds [47:16] and fractional nanoseconds [15:0]. Each field pair is zero-extended to 64 bits and subtracted, giving differences S, N and F. The residence time is ((S*10^9 + N) << 16) + F modulo 2^64.
- R4: With `ctl_cf_en`=1, the 8 bytes starting at byte `cf_off` (byte 0 carries `in_sop`) are read as a big-endian value. On output they are replaced by that value plus the residence time, modulo 2^64.
- R5: With `ctl_zero_en`=1, bytes `zero_off` and `zero_off`+1 leave as 0x00.
- R6: With `ctl_fix_en`=1, an applied correction rewrite, and `fix_off` >= `cf_off`+8, the big-endian word at `fix_off` is patched to keep the ones-complement sum unchanged. Let So and Sn be the ones-complement sums of the four big-endian 16-bit words of the old and new correction field. D = So +' ~Sn, with its bytes swapped when `cf_off` and `fix_off` differ in bit 0. The new word is old +' D, where +' is end-around-carry addition.
- R7: A field whose bytes do not all lie inside the packet is left untouched. The correction rewrite wins over the checksum patch, and the checksum patch wins over zeroing, where they overlap.
- R8: A packet with all four control bits low leaves byte-for-byte identical, with the same start and end markers.
- R9: While `out_valid` is high and `out_ready` low, the output beat holds still. Every accepted input beat leaves exactly once and in order.
- R10: After reset `out_valid` is low. Once an end-of-packet beat is accepted, `in_ready` stays low until that packet's last beat has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts input beat |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of packet |
| in_eop | input | 1 | Last byte of packet |
| ctl_cf_en | input | 1 | Add residence time to correction field |
| ctl_fmt64 | input | 1 | 1: 64-bit timestamps, 0: 96-bit |
| ctl_zero_en | input | 1 | Clear IPv4 UDP checksum |
| ctl_fix_en | input | 1 | Patch IPv6 checksum-correction word |
| cf_off | input | 16 | Byte offset of correction field |
| zero_off | input | 16 | Byte offset of checksum to clear |
| fix_off | input | 16 | Byte offset of checksum-correction word |
| ts_ingress | input | 96 | Ingress timestamp |
| ts_egress | input | 96 | Egress timestamp |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of packet |
| out_eop | output | 1 | Last byte of packet |

## Verification
A corrupted byte position or a stale field register shows up as a wrong byte at a computed offset, in the very packet that carries it. A corrupted delay-line pointer or count shows up as a reordered, repeated or missing byte, or as a start/end marker in the wrong place. A wrong drain flag shows up within one packet, as an input accepted too early or an output that never comes. Every output handshake is compared against a model packet built from the requirements, so any such fault is caught at the first byte it touches.

// File: rtl/ptp_cfu_pkg.sv
package ptp_cfu_pkg;
  localparam int OFF_W = 16;
  localparam int POS_W = OFF_W + 1;
  localparam int TS_W  = 96;
  localparam int CF_W  = 64;
  localparam logic [63:0] NS_PER_S = 64'd1_000_000_000;

  typedef struct packed {
    logic             cf_en;
    logic             fmt64;
    logic             zero_en;
    logic             fix_en;
    logic [OFF_W-1:0] cf_off;
    logic [OFF_W-1:0] zero_off;
    logic [OFF_W-1:0] fix_off;
  } pkt_ctl_t;

  typedef struct packed {
    logic [7:0]       data;
    logic             sop;
    logic             eop;
    logic [POS_W-1:0] pos;
  } beat_t;

  // end-around-carry 16-bit sum
  function automatic logic [15:0] oc_add(logic [15:0] a, logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[15:0] + {15'd0, t[16]};
  endfunction

  function automatic logic [15:0] oc_fold64(logic [63:0] x);
    return oc_add(oc_add(x[63:48], x[47:32]), oc_add(x[31:16], x[15:0]));
  endfunction

  function automatic logic [15:0] fix_patch(logic [15:0] old_word, logic [63:0] old_cf,
                                            logic [63:0] new_cf, logic swap);
    logic [15:0] d;
    d = oc_add(oc_fold64(old_cf), ~oc_fold64(new_cf));
    if (swap) d = {d[7:0], d[15:8]};
    return oc_add(old_word, d);
  endfunction

  function automatic logic [63:0] resid_calc(logic fmt64, logic [TS_W-1:0] eg,
                                             logic [TS_W-1:0] ig);
    logic [63:0] sd, nd, fd;
    sd = {16'd0, eg[95:48]} - {16'd0, ig[95:48]};
    nd = {32'd0, eg[47:16]} - {32'd0, ig[47:16]};
    fd = {48'd0, eg[15:0]} - {48'd0, ig[15:0]};
    if (fmt64) return eg[63:0] - ig[63:0];
    return (((sd * NS_PER_S) + nd) << 16) + fd;
  endfunction
endpackage

// File: rtl/cfu_delay_line.sv
module cfu_delay_line #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/cfu_field_track.sv
module cfu_field_track
  import ptp_cfu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             sop,
  input  logic [7:0]       data,
  input  logic [POS_W-1:0] pos,
  input  pkt_ctl_t         ctl_in,
  input  logic [TS_W-1:0]  ts_eg,
  input  logic [TS_W-1:0]  ts_ig,
  output logic [POS_W-1:0] cf_lo,
  output logic [POS_W-1:0] fix_lo,
  output logic [POS_W-1:0] zero_lo,
  output logic [CF_W-1:0]  new_cf,
  output logic [15:0]      new_fix,
  output logic             cf_ok,
  output logic             fix_ok,
  output logic             zero_ok
);
  pkt_ctl_t         ctl_q, ctl_d, cur;
  logic [CF_W-1:0]  res_q, res_d, old_q, old_d, ncf_q, ncf_d;
  logic [7:0]       fhi_q, fhi_d;
  logic [15:0]      nfx_q, nfx_d;
  logic             cfok_q, cfok_d, fxok_q, fxok_d, zok_q, zok_d;
  logic [POS_W-1:0] cf_s, cf_e, fx_s, fx_e, z_e;
  logic             cf_hit, fix_hit, zero_hit, in_cf, start;

  always_comb begin
    cur   = sop ? ctl_in : ctl_q;
    start = fire && sop;
    cf_s  = {1'b0, cur.cf_off};
    cf_e  = cf_s + POS_W'(7);
    fx_s  = {1'b0, cur.fix_off};
    fx_e  = fx_s + POS_W'(1);
    z_e   = {1'b0, cur.zero_off} + POS_W'(1);
    in_cf = (pos >= cf_s) && (pos <= cf_e);

    cf_hit   = fire && cur.cf_en && (pos == cf_e);
    fix_hit  = fire && cur.fix_en && cfok_q && (pos == fx_e) && (fx_s >= cf_s + POS_W'(8));
    zero_hit = fire && cur.zero_en && (pos == z_e);

    ctl_d = start ? ctl_in : ctl_q;
    res_d = start ? resid_calc(ctl_in.fmt64, ts_eg, ts_ig) : res_q;
    old_d = (fire && cur.cf_en && in_cf) ? {old_q[55:0], data} : old_q;
    ncf_d = cf_hit ? ({old_q[55:0], data} + res_q) : ncf_q;
    fhi_d = (fire && pos == fx_s) ? data : fhi_q;
    nfx_d = fix_hit ? fix_patch({fhi_q, data}, old_q, ncf_q, cur.cf_off[0] ^ cur.fix_off[0])
                    : nfx_q;

    cfok_d = start ? 1'b0 : (cf_hit   ? 1'b1 : cfok_q);
    fxok_d = start ? 1'b0 : (fix_hit  ? 1'b1 : fxok_q);
    zok_d  = start ? 1'b0 : (zero_hit ? 1'b1 : zok_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      res_q  <= '0;
      old_q  <= '0;
      ncf_q  <= '0;
      fhi_q  <= '0;
      nfx_q  <= '0;
      cfok_q <= 1'b0;
      fxok_q <= 1'b0;
      zok_q  <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      res_q  <= res_d;
      old_q  <= old_d;
      ncf_q  <= ncf_d;
      fhi_q  <= fhi_d;
      nfx_q  <= nfx_d;
      cfok_q <= cfok_d;
      fxok_q <= fxok_d;
      zok_q  <= zok_d;
    end
  end

  assign cf_lo   = {1'b0, ctl_q.cf_off};
  assign fix_lo  = {1'b0, ctl_q.fix_off};
  assign zero_lo = {1'b0, ctl_q.zero_off};
  assign new_cf  = ncf_q;
  assign new_fix = nfx_q;
  assign cf_ok   = cfok_q;
  assign fix_ok  = fxok_q;
  assign zero_ok = zok_q;
endmodule

// File: rtl/cfu_rewrite.sv
module cfu_rewrite
  import ptp_cfu_pkg::*;
(
  input  beat_t            head,
  input  logic [POS_W-1:0] cf_lo,
  input  logic [POS_W-1:0] fix_lo,
  input  logic [POS_W-1:0] zero_lo,
  input  logic [CF_W-1:0]  new_cf,
  input  logic [15:0]      new_fix,
  input  logic             cf_ok,
  input  logic             fix_ok,
  input  logic             zero_ok,
  output logic [7:0]       data
);
  logic [POS_W-1:0] rel;
  logic [2:0]       idx;

  always_comb begin
    rel  = head.pos - cf_lo;
    idx  = rel[2:0];
    data = head.data;
    if (cf_ok && (head.pos >= cf_lo) && (rel < POS_W'(8)))
      data = new_cf[{~idx, 3'b000} +: 8];
    else if (fix_ok && head.pos == fix_lo)
      data = new_fix[15:8];
    else if (fix_ok && head.pos == fix_lo + POS_W'(1))
      data = new_fix[7:0];
    else if (zero_ok && (head.pos == zero_lo || head.pos == zero_lo + POS_W'(1)))
      data = '0;
  end
endmodule

// File: rtl/ptp_cf_updater.sv
module ptp_cf_updater
  import ptp_cfu_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              ctl_cf_en,
  input  logic              ctl_fmt64,
  input  logic              ctl_zero_en,
  input  logic              ctl_fix_en,
  input  logic [OFF_W-1:0]  cf_off,
  input  logic [OFF_W-1:0]  zero_off,
  input  logic [OFF_W-1:0]  fix_off,
  input  logic [TS_W-1:0]   ts_ingress,
  input  logic [TS_W-1:0]   ts_egress,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int BEAT_W = $bits(beat_t);

  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic [CNT_W-1:0] count;
  logic [POS_W-1:0] pos_q, pos_d, cur_pos;
  logic             drain_q, drain_d, full, ov, of, ir, inf;
  beat_t            beat_in, head;
  logic [BEAT_W-1:0] head_raw;
  pkt_ctl_t         ctl_in;
  logic [POS_W-1:0] cf_lo, fix_lo, zero_lo;
  logic [CF_W-1:0]  new_cf;
  logic [15:0]      new_fix;
  logic             cf_ok, fix_ok, zero_ok;

  // reset asserts at once, leaves after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  always_comb begin
    full    = (count == CNT_W'(DEPTH));
    ov      = (count != '0) && (full || drain_q);
    of      = ov && out_ready;
    ir      = rst_i_n && !drain_q && (!full || of);
    inf     = in_valid && ir;
    cur_pos = in_sop ? '0 : pos_q;
    pos_d   = inf ? ((&cur_pos) ? cur_pos : cur_pos + POS_W'(1)) : pos_q;
    drain_d = (inf && in_eop) ? 1'b1 : ((count == '0) ? 1'b0 : drain_q);
    beat_in = '{data: in_data, sop: in_sop, eop: in_eop, pos: cur_pos};
    ctl_in  = '{cf_en: ctl_cf_en, fmt64: ctl_fmt64, zero_en: ctl_zero_en, fix_en: ctl_fix_en,
                cf_off: cf_off, zero_off: zero_off, fix_off: fix_off};
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pos_q   <= '0;
      drain_q <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      drain_q <= drain_d;
    end
  end

  cfu_delay_line #(.DEPTH(DEPTH), .W(BEAT_W)) u_line (
    .clk(clk), .rst_n(rst_i_n), .push(inf), .pop(of),
    .din(beat_in), .dout(head_raw), .count(count)
  );
  assign head = beat_t'(head_raw);

  cfu_field_track u_track (
    .clk(clk), .rst_n(rst_i_n), .fire(inf), .sop(in_sop), .data(in_data), .pos(cur_pos),
    .ctl_in(ctl_in), .ts_eg(ts_egress), .ts_ig(ts_ingress),
    .cf_lo(cf_lo), .fix_lo(fix_lo), .zero_lo(zero_lo), .new_cf(new_cf), .new_fix(new_fix),
    .cf_ok(cf_ok), .fix_ok(fix_ok), .zero_ok(zero_ok)
  );

  cfu_rewrite u_rw (
    .head(head), .cf_lo(cf_lo), .fix_lo(fix_lo), .zero_lo(zero_lo), .new_cf(new_cf),
    .new_fix(new_fix), .cf_ok(cf_ok), .fix_ok(fix_ok), .zero_ok(zero_ok), .data(out_data)
  );

  assign in_ready  = ir;
  assign out_valid = ov;
  assign out_sop   = head.sop;
  assign out_eop   = head.eop;
endmodule

// File: rtl/ptp_cfu_chk.sv
module ptp_cfu_chk #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_eop,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_eop
);
  logic [15:0] occ_q;
  logic        in_fire, out_fire;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_q + 16'(in_fire) - 16'(out_fire);
  end

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  // R9
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= 16'(DEPTH));

  // R9
  no_phantom_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (occ_q != '0));

  // R10
  drain_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_eop) |=> !in_ready);

  // R10
  empty_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_eop) |=> !out_valid);
endmodule

bind ptp_cf_updater ptp_cfu_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_eop(in_eop),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sop(out_sop), .out_eop(out_eop)
);

// File: tb/sim_ptp_cf_updater.sv
module sim_ptp_cf_updater;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_sop, in_eop;
  logic [7:0]  in_data;
  logic        ctl_cf_en, ctl_fmt64, ctl_zero_en, ctl_fix_en;
  logic [15:0] cf_off, zero_off, fix_off;
  logic [95:0] ts_ingress, ts_egress;
  logic        out_valid, out_ready, out_sop, out_eop;
  logic [7:0]  out_data;

  int n_cmp = 0, n_bad = 0;
  bit bp_mode = 1'b0, gaps = 1'b0;
  logic [9:0]  expq[$];
  string       tagq[$];
  logic [7:0]  pk[];

  always #5 clk = ~clk;

  ptp_cf_updater u0 (.*);

  function automatic logic [15:0] ocs(logic [15:0] a, logic [15:0] b);
    logic [16:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[15:0] + {15'd0, t[16]};
  endfunction

  function automatic logic [63:0] ref_res(bit f64, logic [95:0] eg, logic [95:0] ig);
    longint unsigned s, n, f;
    if (f64) return eg[63:0] - ig[63:0];
    s = longint'(eg[95:48]) - longint'(ig[95:48]);
    n = longint'(eg[47:16]) - longint'(ig[47:16]);
    f = longint'(eg[15:0]) - longint'(ig[15:0]);
    return ((s * 64'd1000000000 + n) << 16) + f;
  endfunction

  function automatic logic [15:0] wsum(logic [63:0] x);
    return ocs(ocs(x[63:48], x[47:32]), ocs(x[31:16], x[15:0]));
  endfunction

  task automatic fail(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s got %h expected %h", req, what, got, exp);
  endtask

  task automatic mk_pkt(int len);
    pk = new[len];
    foreach (pk[i]) pk[i] = 8'($urandom);
  endtask

  // builds the expected packet from the requirements, then drives pk
  task automatic send_pkt(bit cfe, bit f64, bit ze, bit fxe, int cfo, int zo, int fxo,
                          logic [95:0] eg, logic [95:0] ig, bit scramble, string tag);
    int len = pk.size();
    logic [7:0] e[];
    logic [63:0] oldcf, newcf;
    logic [15:0] d, oldfx, nf;
    bit cfa, fxa;
    e = new[len];
    foreach (pk[i]) e[i] = pk[i];
    cfa = cfe && (cfo + 8 <= len);                                  // R4 R7
    fxa = cfa && fxe && (fxo >= cfo + 8) && (fxo + 2 <= len);       // R6 R7
    if (ze && zo + 2 <= len) begin e[zo] = 8'h00; e[zo+1] = 8'h00; end  // R5
    if (fxa) begin
      for (int k = 0; k < 8; k++) oldcf = {oldcf[55:0], pk[cfo+k]};
      newcf = oldcf + ref_res(f64, eg, ig);
      oldfx = {pk[fxo], pk[fxo+1]};
      d = ocs(wsum(oldcf), ~wsum(newcf));
      if (((cfo ^ fxo) & 1) != 0) d = {d[7:0], d[15:8]};
      nf = ocs(oldfx, d);
      e[fxo] = nf[15:8]; e[fxo+1] = nf[7:0];
    end
    if (cfa) begin
      for (int k = 0; k < 8; k++) oldcf = {oldcf[55:0], pk[cfo+k]};
      newcf = oldcf + ref_res(f64, eg, ig);                         // R2 R3
      for (int k = 0; k < 8; k++) e[cfo+k] = newcf[63-8*k -: 8];
    end
    for (int i = 0; i < len; i++) begin
      expq.push_back({i == 0, i == len - 1, e[i]});
      tagq.push_back(tag);
    end
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid = 1'b1; in_data = pk[i]; in_sop = (i == 0); in_eop = (i == len - 1);
      if (i == 0) begin
        ctl_cf_en = cfe; ctl_fmt64 = f64; ctl_zero_en = ze; ctl_fix_en = fxe;
        cf_off = 16'(cfo); zero_off = 16'(zo); fix_off = 16'(fxo);
        ts_egress = eg; ts_ingress = ig;
      end else if (scramble) begin                                  // R1
        ctl_cf_en = ~cfe; ctl_fmt64 = ~f64; ctl_zero_en = ~ze; ctl_fix_en = ~fxe;
        cf_off = 16'($urandom); zero_off = 16'($urandom); fix_off = 16'($urandom);
        ts_egress = {$urandom, $urandom, $urandom}; ts_ingress = {$urandom, $urandom, $urandom};
      end
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (in_ready !== 1'b0 && expq.size() != 0) fail("R10", "in_ready after end", 32'(in_ready), 0);
    @(posedge clk); #1;
  endtask

  // output monitor, compared on every clock
  logic       stall_q = 1'b0;
  logic [9:0] held_q;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_q) begin
        n_cmp++;
        if (!(out_valid && {out_sop, out_eop, out_data} == held_q))
          fail("R9", "stalled beat moved", {22'd0, out_sop, out_eop, out_data}, {22'd0, held_q});
      end
      stall_q = out_valid && !out_ready;
      held_q  = {out_sop, out_eop, out_data};
      if (out_valid && out_ready) begin
        n_cmp++;
        if (expq.size() == 0) fail("R9", "unexpected beat", {22'd0, out_sop, out_eop, out_data}, 0);
        else begin
          logic [9:0] ex;
          string tg;
          ex = expq.pop_front(); tg = tagq.pop_front();
          if ({out_sop, out_eop, out_data} !== ex)
            fail(tg, "output beat", {22'd0, out_sop, out_eop, out_data}, {22'd0, ex});
        end
      end
    end else stall_q = 1'b0;
  end

  always @(posedge clk) begin
    #1;
    out_ready = bp_mode ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fail("R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [95:0] eg, ig;
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    ctl_cf_en = 0; ctl_fmt64 = 0; ctl_zero_en = 0; ctl_fix_en = 0;
    cf_off = '0; zero_off = '0; fix_off = '0; ts_egress = '0; ts_ingress = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_cmp++; if (out_valid !== 1'b0) fail("R10", "out_valid after reset", 32'(out_valid), 0);
    n_cmp++; if (in_ready !== 1'b1) fail("R10", "in_ready after reset", 32'(in_ready), 1);
    @(posedge clk); #1;

    // R8 plain pass-through, steady and with stalls
    mk_pkt(40); send_pkt(0, 0, 0, 0, 5, 6, 20, '0, '0, 0, "R8");
    bp_mode = 1; gaps = 1;
    mk_pkt(33); send_pkt(0, 1, 0, 0, 0, 0, 0, {3{32'h1234_5678}}, '0, 0, "R8 R9");
    mk_pkt(1);  send_pkt(0, 0, 0, 0, 0, 0, 0, '0, '0, 0, "R8");

    // R2 R4: 64-bit format
    eg = {32'd0, 48'd5000, 16'h8000}; ig = {32'd0, 48'd1200, 16'h4000};
    mk_pkt(40); send_pkt(1, 1, 0, 0, 10, 0, 0, eg, ig, 0, "R2 R4");
    // R3: seconds carry with negative nanosecond difference
    eg = {48'd7, 32'd100, 16'd3}; ig = {48'd5, 32'd999_999_000, 16'd9};
    mk_pkt(50); send_pkt(1, 0, 0, 0, 22, 0, 0, eg, ig, 0, "R3 R4");
    mk_pkt(8);  send_pkt(1, 0, 0, 0, 0, 0, 0, eg, ig, 0, "R3 R4");
    // R5
    mk_pkt(44); send_pkt(0, 0, 1, 0, 0, 26, 0, eg, ig, 0, "R5");
    // R6 same and opposite parity
    mk_pkt(70); send_pkt(1, 1, 0, 1, 34, 0, 60, {3{32'hdead_beef}}, {3{32'h0bad_f00d}}, 0, "R6");
    mk_pkt(70); send_pkt(1, 0, 0, 1, 34, 0, 61, {3{32'h7777_1111}}, {3{32'h2222_9999}}, 0, "R6");
    // R7 fields past the end, overlaps
    mk_pkt(12); send_pkt(1, 1, 1, 1, 8, 11, 40, eg, ig, 0, "R7");
    mk_pkt(30); send_pkt(1, 1, 1, 1, 4, 6, 8, eg, ig, 0, "R7");
    // R1 controls change after the first beat
    mk_pkt(60); send_pkt(1, 0, 1, 1, 14, 2, 40, eg, ig, 1, "R1");

    for (int n = 0; n < 40; n++) begin
      int len = 1 + $urandom % 90;
      mk_pkt(len);
      send_pkt($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 80,
               $urandom % 90, $urandom % 90, {$urandom, $urandom, $urandom},
               {$urandom, $urandom, $urandom}, $urandom % 2, "R1 R4 R5 R6 R7");
    end

    for (int w = 0; w < 2000 && expq.size() != 0; w++) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (expq.size() != 0) fail("R9", "beats never delivered", 32'(expq.size()), 0);
    finish_run();
  end
endmodule